// File: doc/BRIEF.md
# Accelerator Control and Status Register Slave

This block gives a processor register-level control of a compute accelerator over an AXI4-Lite port. Software programs a source pointer, a destination pointer and a transfer count. It then writes a command word to launch the job and polls a read-only status word until the job reports completion. The block turns the launch write into a single-cycle kick pulse toward the datapath. It drives the three programmed values as steady outputs, and it reflects the datapath's busy, done and fault flags back to software. An interrupt output can be enabled from the command word.

The slave takes single-beat transfers only. A write address and its write data are accepted independently, in either order or in the same cycle. The register is updated only once both have arrived, and an OKAY write response follows. A read takes a snapshot of the addressed register when its address is accepted. That value is held on the read data channel until the master takes it.

Top module: `acc_csr_axil`

## Requirements
- R1: After a synchronous active-high reset, all writable registers are zero, `kick_o` and `irq_o` are 0, `s_bvalid` and `s_rvalid` are 0, and `s_awready`, `s_wready` and `s_arready` are 1.
- R2: The word-aligned byte offsets are: command word at 0x00, status at 0x04, source pointer at 0x08, destination pointer at 0x0C and transfer count at 0x10. Address bits [1:0] are ignored. The pointer and count registers read back what was written and drive `src_addr_o`, `dst_addr_o` and `xfer_len_o`.
- R3: A write's address and data may be accepted in either order or in the same cycle. No register or output changes before both have been accepted. The change becomes visible in the same cycle that `s_bvalid` rises.
- R4: Every write completes with `s_bresp` = 2'b00 (OKAY). `s_bvalid` stays high until `s_bready` is sampled high, and drops in the following cycle.
- R5: Bit i of `s_wstrb` enables byte i (bits 8i+7..8i) of the written register. Unstrobed bytes keep their value. Bits 0 and 1 of the command word are in byte 0.
- R6: Writing the command word with byte 0 enabled and bit 0 = 1 makes `kick_o` high for exactly one cycle: the cycle in which `s_bvalid` rises. Bit 0 reads back as 0 afterwards. Any other write leaves `kick_o` low.
- R7: Command bit 1 is a read/write interrupt enable. Command bits 31:2 always read as 0.
- R8: Status is read-only: bit 0 = `busy_i`, bit 1 = `done_i`, bit 2 = `fault_i`, and bits 31:3 read as 0. A write to it changes nothing and still returns OKAY.
- R9: A read of any offset outside the map (for example 0x14 or 0xFC) returns zero. A write there changes nothing and returns OKAY.
- R10: Once `s_rvalid` is high, it and `s_rdata` hold steady until `s_rready` is sampled high. `s_rresp` is 2'b00, and `s_arready` is low while a read response is pending.
- R11: `irq_o` is high exactly while `done_i` is 1 and the interrupt enable (command bit 1) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| kick_o | output | 1 | One-cycle launch pulse to the datapath |
| src_addr_o | output | 32 | Programmed source pointer |
| dst_addr_o | output | 32 | Programmed destination pointer |
| xfer_len_o | output | 32 | Programmed transfer count |
| busy_i | input | 1 | Datapath busy flag |
| done_i | input | 1 | Datapath done flag |
| fault_i | input | 1 | Datapath fault flag |
| irq_o | output | 1 | Interrupt, done gated by the enable bit |

## Verification
The bench builds the block with its default `ADDR_W` = 8, so the whole 256-byte window can be addressed. This brings unmapped offsets such as 0x14 and 0xFC within reach, along with unaligned offsets whose low two bits must be ignored. With that window the bench presents write address and data together, address first and data first. It stalls both the write response and the read response to show they hold. A reference model in the bench follows every committed write byte by byte and is compared against the pointer outputs, the kick pulse and the interrupt on every clock.

// File: rtl/acc_csr_pkg.sv
`timescale 1ns/1ps
package acc_csr_pkg;

    localparam int CSR_DW   = 32;
    localparam int CSR_SW   = CSR_DW / 8;
    localparam int WORD_LSB = $clog2(CSR_SW);
    localparam int N_PTR    = 3;

    // command word bit positions
    localparam int CMD_GO = 0;
    localparam int CMD_IE = 1;
    // status word bit positions
    localparam int ST_BUSY  = 0;
    localparam int ST_DONE  = 1;
    localparam int ST_FAULT = 2;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [2:0] {
        SEL_CMD  = 3'd0,
        SEL_STAT = 3'd1,
        SEL_SRC  = 3'd2,
        SEL_DST  = 3'd3,
        SEL_LEN  = 3'd4,
        SEL_NONE = 3'd7
    } csr_sel_e;

    typedef struct packed {
        csr_sel_e              sel;
        logic [CSR_DW-1:0]     data;
        logic [CSR_SW-1:0]     strb;
    } wr_req_t;

    function automatic csr_sel_e csr_decode(input logic [31:0] widx);
        case (widx)
            32'd0:   return SEL_CMD;
            32'd1:   return SEL_STAT;
            32'd2:   return SEL_SRC;
            32'd3:   return SEL_DST;
            32'd4:   return SEL_LEN;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic csr_sel_e ptr_sel(input int idx);
        case (idx)
            0:       return SEL_SRC;
            1:       return SEL_DST;
            default: return SEL_LEN;
        endcase
    endfunction

    function automatic logic [CSR_DW-1:0] merge_bytes(
        input logic [CSR_DW-1:0] old_v,
        input logic [CSR_DW-1:0] new_v,
        input logic [CSR_SW-1:0] strb
    );
        logic [CSR_DW-1:0] r;
        r = old_v;
        for (int b = 0; b < CSR_SW; b++) begin
            if (strb[b]) r[8*b +: 8] = new_v[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/acc_csr_wr.sv
`timescale 1ns/1ps
module acc_csr_wr
    import acc_csr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  csr_sel_e            aw_sel,
    input  logic                awvalid,
    output logic                awready,
    input  logic [CSR_DW-1:0]   wdata,
    input  logic [CSR_SW-1:0]   wstrb,
    input  logic                wvalid,
    output logic                wready,
    output logic                bvalid,
    input  logic                bready,
    output logic                wr_valid,
    output wr_req_t             wr_req
);

    logic              aw_held;
    logic              w_held;
    csr_sel_e          sel_q;
    logic [CSR_DW-1:0] data_q;
    logic [CSR_SW-1:0] strb_q;
    logic              bvalid_q;
    logic              commit;

    assign awready = !aw_held;
    assign wready  = !w_held;
    assign commit  = aw_held && w_held && !bvalid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_held  <= 1'b0;
            w_held   <= 1'b0;
            sel_q    <= SEL_NONE;
            data_q   <= '0;
            strb_q   <= '0;
            bvalid_q <= 1'b0;
        end else begin
            if (awvalid && !aw_held) begin
                aw_held <= 1'b1;
                sel_q   <= aw_sel;
            end
            if (wvalid && !w_held) begin
                w_held <= 1'b1;
                data_q <= wdata;
                strb_q <= wstrb;
            end
            if (commit) begin
                aw_held  <= 1'b0;
                w_held   <= 1'b0;
                bvalid_q <= 1'b1;
            end else if (bvalid_q && bready) begin
                bvalid_q <= 1'b0;
            end
        end
    end

    assign bvalid      = bvalid_q;
    assign wr_valid    = commit;
    assign wr_req.sel  = sel_q;
    assign wr_req.data = data_q;
    assign wr_req.strb = strb_q;

endmodule

// File: rtl/acc_csr_regs.sv
`timescale 1ns/1ps
module acc_csr_regs
    import acc_csr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_valid,
    input  wr_req_t                 wr_req,
    input  csr_sel_e                rd_sel,
    output logic [CSR_DW-1:0]       rd_val,
    input  logic                    busy_i,
    input  logic                    done_i,
    input  logic                    fault_i,
    output logic                    kick_o,
    output logic                    irq_o,
    output logic [CSR_DW-1:0]       ptr_o [N_PTR]
);

    logic              go_q;
    logic              ie_q;
    logic [CSR_DW-1:0] ptr_q [N_PTR];
    logic              cmd_wr;

    assign cmd_wr = wr_valid && (wr_req.sel == SEL_CMD) && wr_req.strb[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q <= 1'b0;
            ie_q <= 1'b0;
        end else begin
            go_q <= cmd_wr && wr_req.data[CMD_GO];
            if (cmd_wr) ie_q <= wr_req.data[CMD_IE];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_PTR; i++) begin
            if (rst) begin
                ptr_q[i] <= '0;
            end else if (wr_valid && wr_req.sel == ptr_sel(i)) begin
                ptr_q[i] <= merge_bytes(ptr_q[i], wr_req.data, wr_req.strb);
            end
        end
    end

    for (genvar g = 0; g < N_PTR; g++) begin : g_ptr_out
        assign ptr_o[g] = ptr_q[g];
    end

    always_comb begin
        rd_val = '0;
        case (rd_sel)
            SEL_CMD: begin
                rd_val[CMD_GO] = go_q;
                rd_val[CMD_IE] = ie_q;
            end
            SEL_STAT: begin
                rd_val[ST_BUSY]  = busy_i;
                rd_val[ST_DONE]  = done_i;
                rd_val[ST_FAULT] = fault_i;
            end
            default: begin
                for (int i = 0; i < N_PTR; i++) begin
                    if (rd_sel == ptr_sel(i)) rd_val = ptr_q[i];
                end
            end
        endcase
    end

    assign kick_o = go_q;
    assign irq_o  = done_i && ie_q;

endmodule

// File: rtl/acc_csr_rd.sv
`timescale 1ns/1ps
module acc_csr_rd
    import acc_csr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                arvalid,
    output logic                arready,
    input  logic [CSR_DW-1:0]   rd_val,
    output logic [CSR_DW-1:0]   rdata,
    output logic                rvalid,
    input  logic                rready
);

    logic              rvalid_q;
    logic [CSR_DW-1:0] rdata_q;

    assign arready = !rvalid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (arvalid && !rvalid_q) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_val;
        end else if (rvalid_q && rready) begin
            rvalid_q <= 1'b0;
        end
    end

    assign rvalid = rvalid_q;
    assign rdata  = rdata_q;

endmodule

// File: rtl/acc_csr_axil.sv
`timescale 1ns/1ps
module acc_csr_axil
    import acc_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [CSR_DW-1:0]   s_wdata,
    input  logic [CSR_SW-1:0]   s_wstrb,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    input  logic [ADDR_W-1:0]   s_araddr,
    input  logic                s_arvalid,
    output logic                s_arready,
    output logic [CSR_DW-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                s_rvalid,
    input  logic                s_rready,
    output logic                kick_o,
    output logic [CSR_DW-1:0]   src_addr_o,
    output logic [CSR_DW-1:0]   dst_addr_o,
    output logic [CSR_DW-1:0]   xfer_len_o,
    input  logic                busy_i,
    input  logic                done_i,
    input  logic                fault_i,
    output logic                irq_o
);

    localparam int WIDX_W = ADDR_W - WORD_LSB;

    csr_sel_e          aw_sel;
    csr_sel_e          ar_sel;
    logic              wr_valid;
    wr_req_t           wr_req;
    logic [CSR_DW-1:0] rd_val;
    logic [CSR_DW-1:0] ptr [N_PTR];
    logic              unused_lo;

    assign unused_lo = ^{s_awaddr[WORD_LSB-1:0], s_araddr[WORD_LSB-1:0]};

    assign aw_sel = csr_decode(32'(s_awaddr[ADDR_W-1 -: WIDX_W]));
    assign ar_sel = csr_decode(32'(s_araddr[ADDR_W-1 -: WIDX_W]));

    acc_csr_wr u_wr (
        .clk      (clk),
        .rst      (rst),
        .aw_sel   (aw_sel),
        .awvalid  (s_awvalid),
        .awready  (s_awready),
        .wdata    (s_wdata),
        .wstrb    (s_wstrb),
        .wvalid   (s_wvalid),
        .wready   (s_wready),
        .bvalid   (s_bvalid),
        .bready   (s_bready),
        .wr_valid (wr_valid),
        .wr_req   (wr_req)
    );

    acc_csr_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_req   (wr_req),
        .rd_sel   (ar_sel),
        .rd_val   (rd_val),
        .busy_i   (busy_i),
        .done_i   (done_i),
        .fault_i  (fault_i),
        .kick_o   (kick_o),
        .irq_o    (irq_o),
        .ptr_o    (ptr)
    );

    acc_csr_rd u_rd (
        .clk     (clk),
        .rst     (rst),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .rd_val  (rd_val),
        .rdata   (s_rdata),
        .rvalid  (s_rvalid),
        .rready  (s_rready)
    );

    assign s_bresp    = RESP_OKAY;
    assign s_rresp    = RESP_OKAY;
    assign src_addr_o = ptr[0];
    assign dst_addr_o = ptr[1];
    assign xfer_len_o = ptr[2];

endmodule

// File: rtl/acc_csr_chk.sv
`timescale 1ns/1ps
module acc_csr_chk (
    input logic        clk,
    input logic        rst,
    input logic        s_bvalid,
    input logic        s_bready,
    input logic [1:0]  s_bresp,
    input logic        s_rvalid,
    input logic        s_rready,
    input logic [31:0] s_rdata,
    input logic [1:0]  s_rresp,
    input logic        s_arready,
    input logic        kick_o,
    input logic [31:0] src_addr_o,
    input logic [31:0] dst_addr_o,
    input logic [31:0] xfer_len_o,
    input logic        done_i,
    input logic        irq_o
);

    AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        s_bvalid && !s_bready |=> s_bvalid); // R4
    AST_BRESP_OKAY: assert property (@(posedge clk) disable iff (rst)
        s_bvalid |-> s_bresp == 2'b00); // R4
    AST_BVALID_DROP: assert property (@(posedge clk) disable iff (rst)
        s_bvalid && s_bready |=> !s_bvalid); // R4
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata)); // R10
    AST_NO_AR_PENDING: assert property (@(posedge clk) disable iff (rst)
        s_rvalid |-> !s_arready); // R10
    AST_RRESP_OKAY: assert property (@(posedge clk) disable iff (rst)
        s_rvalid |-> s_rresp == 2'b00); // R10
    AST_KICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        kick_o |=> !kick_o); // R6
    AST_KICK_AT_RESP: assert property (@(posedge clk) disable iff (rst)
        kick_o |-> $rose(s_bvalid)); // R6
    AST_SRC_AT_RESP: assert property (@(posedge clk) disable iff (rst)
        !$stable(src_addr_o) |-> $rose(s_bvalid)); // R3
    AST_DST_AT_RESP: assert property (@(posedge clk) disable iff (rst)
        !$stable(dst_addr_o) |-> $rose(s_bvalid)); // R3
    AST_LEN_AT_RESP: assert property (@(posedge clk) disable iff (rst)
        !$stable(xfer_len_o) |-> $rose(s_bvalid)); // R3
    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> done_i); // R11

endmodule

bind acc_csr_axil acc_csr_chk u_chk (.*);

// File: tb/sim_acc_csr_axil.sv
`timescale 1ns/1ps
module sim_acc_csr_axil;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  s_awaddr = '0;
    logic        s_awvalid = 1'b0;
    logic        s_awready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_wvalid = 1'b0;
    logic        s_wready;
    logic [1:0]  s_bresp;
    logic        s_bvalid;
    logic        s_bready = 1'b0;
    logic [7:0]  s_araddr = '0;
    logic        s_arvalid = 1'b0;
    logic        s_arready;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rvalid;
    logic        s_rready = 1'b0;
    logic        kick_o;
    logic [31:0] src_addr_o;
    logic [31:0] dst_addr_o;
    logic [31:0] xfer_len_o;
    logic        busy_i = 1'b0;
    logic        done_i = 1'b0;
    logic        fault_i = 1'b0;
    logic        irq_o;

    always #5 clk = ~clk;

    acc_csr_axil #(.ADDR_W(8)) u0 (.*);

    int n_chk = 0;
    int n_err = 0;

    // reference model state
    logic [31:0] m_src = '0;
    logic [31:0] m_dst = '0;
    logic [31:0] m_len = '0;
    bit          m_ie = 1'b0;
    bit          exp_kick = 1'b0;
    bit          cmp_en = 1'b0;

    task automatic chk(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] s);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d,
                               input logic [3:0] s);
        case (a[7:2])
            6'd0: if (s[0]) begin
                m_ie = d[1];
                if (d[0]) exp_kick = 1'b1;
            end
            6'd2: m_src = mrg(m_src, d, s);
            6'd3: m_dst = mrg(m_dst, d, s);
            6'd4: m_len = mrg(m_len, d, s);
            default: ;
        endcase
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a[7:2])
            6'd0: return {30'b0, m_ie, 1'b0};
            6'd1: return {29'b0, fault_i, done_i, busy_i};
            6'd2: return m_src;
            6'd3: return m_dst;
            6'd4: return m_len;
            default: return 32'h0;
        endcase
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        #1;
        if (cmp_en) begin
            chk(src_addr_o == m_src, "R2 R3 src_addr_o", src_addr_o, m_src);
            chk(dst_addr_o == m_dst, "R2 R3 dst_addr_o", dst_addr_o, m_dst);
            chk(xfer_len_o == m_len, "R2 R3 xfer_len_o", xfer_len_o, m_len);
            chk(kick_o == exp_kick, "R6 kick_o", 32'(kick_o), 32'(exp_kick));
            chk(irq_o == (m_ie && done_i), "R11 irq_o", 32'(irq_o), 32'(m_ie && done_i));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                      input int aw_dly, input int w_dly, input int bstall);
        int  cyc = 0;
        bit  aw_ok = 0;
        bit  w_ok = 0;
        bit  seen = 0;
        bit  fin = 0;
        int  stall = bstall;
        int  guard = 0;
        while (!(aw_ok && w_ok)) begin
            @(negedge clk);
            s_awaddr  = a;
            s_wdata   = d;
            s_wstrb   = s;
            s_awvalid = !aw_ok && (cyc >= aw_dly);
            s_wvalid  = !w_ok && (cyc >= w_dly);
            if (s_awvalid && s_awready) aw_ok = 1;
            if (s_wvalid && s_wready) w_ok = 1;
            cyc++;
        end
        while (!fin && guard < 50) begin
            @(negedge clk);
            guard++;
            s_awvalid = 1'b0;
            s_wvalid  = 1'b0;
            exp_kick  = 1'b0;
            if (s_bready) begin
                s_bready = 1'b0;
                fin = 1;
                chk(!s_bvalid, "R4 bvalid drops after handshake", 32'(s_bvalid), 0);
            end else if (s_bvalid) begin
                if (!seen) begin
                    seen = 1;
                    model_write(a, d, s);
                    chk(s_bresp == 2'b00, "R4 bresp OKAY", 32'(s_bresp), 0);
                end else begin
                    chk(1'b1, "R4 bvalid held in stall", 1, 1);
                end
                if (stall > 0) stall--;
                else s_bready = 1'b1;
            end else if (seen) begin
                chk(1'b0, "R4 bvalid dropped without bready", 0, 1);
                fin = 1;
            end
        end
    endtask

    task automatic rd(input logic [7:0] a, input int rstall, input string tag);
        logic [31:0] exp;
        logic [31:0] first;
        @(negedge clk);
        s_araddr  = a;
        s_arvalid = 1'b1;
        exp = model_read(a);
        chk(s_arready, "R10 arready idle", 32'(s_arready), 1);
        @(negedge clk);
        s_arvalid = 1'b0;
        chk(s_rvalid, "R10 rvalid after address", 32'(s_rvalid), 1);
        chk(s_rdata == exp, tag, s_rdata, exp);
        chk(!s_arready, "R10 arready low while pending", 32'(s_arready), 0);
        first = s_rdata;
        for (int i = 0; i < rstall; i++) begin
            @(negedge clk);
            chk(s_rvalid && s_rdata == first, "R10 read held in stall", s_rdata, first);
        end
        chk(s_rresp == 2'b00, "R10 rresp OKAY", 32'(s_rresp), 0);
        s_rready = 1'b1;
        @(negedge clk);
        s_rready = 1'b0;
        chk(!s_rvalid, "R10 rvalid drops after handshake", 32'(s_rvalid), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_en = 1'b1;
        #2;
        // R1 reset state
        chk(!kick_o && !irq_o, "R1 kick/irq after reset", {kick_o, irq_o}, 0);
        chk(!s_bvalid && !s_rvalid, "R1 no response after reset", {s_bvalid, s_rvalid}, 0);
        chk(s_awready && s_wready && s_arready, "R1 ready after reset",
            {s_awready, s_wready, s_arready}, 3'b111);
        chk(src_addr_o == 0 && dst_addr_o == 0 && xfer_len_o == 0, "R1 pointers zero",
            src_addr_o | dst_addr_o | xfer_len_o, 0);
        rd(8'h00, 0, "R1 command after reset");
        rd(8'h08, 0, "R1 source after reset");

        // R2 R3: address and data together
        wr(8'h08, 32'h1000_0040, 4'hF, 0, 0, 0);
        rd(8'h08, 0, "R2 source readback");
        // R3: address first
        wr(8'h0C, 32'h2000_0080, 4'hF, 0, 3, 0);
        rd(8'h0C, 0, "R3 destination after address-first write");
        // R3 R4: data first with response stall
        wr(8'h10, 32'h0000_0100, 4'hF, 2, 0, 3);
        rd(8'h10, 0, "R4 count after stalled response");
        // R5 partial strobes
        wr(8'h08, 32'hAABB_CCDD, 4'b0101, 0, 0, 0);
        rd(8'h08, 0, "R5 source after partial strobe");
        chk(src_addr_o == 32'h10BB_00DD, "R5 merged bytes", src_addr_o, 32'h10BB_00DD);
        // R2 low address bits ignored
        rd(8'h0B, 0, "R2 unaligned offset reads source");
        wr(8'h0E, 32'h3000_0000, 4'b1000, 1, 0, 0);
        rd(8'h0C, 0, "R2 unaligned write reaches destination");

        // R6 R7 launch with interrupt enable
        wr(8'h00, 32'h0000_0003, 4'hF, 0, 0, 0);
        rd(8'h00, 0, "R6 R7 command reads enable only");
        wr(8'h00, 32'hFFFF_FFFC, 4'hF, 0, 0, 0);
        rd(8'h00, 0, "R7 upper command bits read zero");
        wr(8'h00, 32'hFFFF_FFFE, 4'hF, 0, 0, 1);
        rd(8'h00, 0, "R7 enable set");
        // R5 R6 byte 0 not strobed: no kick, enable kept
        wr(8'h00, 32'h0000_0001, 4'b1110, 0, 0, 0);
        rd(8'h00, 0, "R5 R6 unstrobed command byte");

        // R8 status
        busy_i = 1'b1;
        fault_i = 1'b1;
        rd(8'h04, 0, "R8 status busy and fault");
        wr(8'h04, 32'hFFFF_FFFF, 4'hF, 0, 0, 0);
        rd(8'h04, 0, "R8 status after ignored write");
        rd(8'h00, 0, "R8 command untouched by status write");
        done_i = 1'b1;
        @(negedge clk);
        #2;
        chk(irq_o, "R11 irq with done and enable", 32'(irq_o), 1);
        rd(8'h04, 2, "R8 status all flags");
        wr(8'h00, 32'h0, 4'hF, 0, 0, 0);
        @(negedge clk);
        #2;
        chk(!irq_o, "R11 irq off when enable cleared", 32'(irq_o), 0);
        busy_i = 1'b0;
        fault_i = 1'b0;
        done_i = 1'b0;

        // R9 unmapped
        rd(8'h14, 0, "R9 unmapped 0x14 reads zero");
        rd(8'hFC, 1, "R9 unmapped 0xFC reads zero");
        wr(8'h14, 32'hFFFF_FFFF, 4'hF, 0, 0, 0);
        wr(8'h40, 32'hDEAD_BEEF, 4'hF, 0, 2, 0);
        rd(8'h08, 0, "R9 source untouched by unmapped writes");
        rd(8'h10, 0, "R9 count untouched by unmapped writes");

        // R10 read stall and back-to-back
        rd(8'h0C, 4, "R10 stalled read value");
        rd(8'h10, 0, "R10 back-to-back read");

        // R6 second launch with enable off
        wr(8'h00, 32'h0000_0001, 4'h1, 0, 0, 2);
        rd(8'h00, 0, "R6 start bit self-cleared");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule